// File: doc/BRIEF.md
# DDR3 ZQ Calibration Command Scheduler

This block sits beside the main command scheduler of a DDR3 controller and decides when a ZQ calibration command goes to each rank. It accepts three kinds of request per rank: a power-up calibration, a calibration after leaving self refresh, and a periodic short calibration. It queues them and issues each one as a single command strobe with the rank and the A10 value. A10 high means a long calibration and A10 low means a short one.

Before it issues a command to a rank, the rank must report that all its banks are closed, and the row-precharge time since the last precharge-all must have elapsed. After the command the rank is held in a quiet window whose length depends on the kind of calibration. The first long calibration after reset uses the longest window. Later long calibrations use a shorter one, and short calibrations use the shortest. While a rank is in its window, the block forces that rank's clock enable high and its on-die termination low, reports the rank busy so the main scheduler sends it only NOPs, and pulses a done flag when the window ends.

When both ranks share one calibration resistor, the two windows are kept apart. Without sharing, the second rank may start while the first is still calibrating. The block never waits on DLL lock and never calibrates unless asked.

Top module: `zq_cal_sched`

## Requirements
- R1: A calibration command is a one-cycle strobe on `zqCmd` with the target on `zqRank`. `zqA10` is 1 for a long calibration (power-up or self-refresh-exit request) and 0 for a short one (periodic request).
- R2: Among ready requests, the power-up class wins over the self-refresh-exit class, which wins over the periodic class. This ordering applies across all ranks. Within a class the lowest rank index wins.
- R3: A rank's `rankBusy` is high for exactly N cycles, starting with the issue cycle. N is TZQINIT for the first long calibration of that rank after reset, TZQOPER for every later long one, and TZQCS for a short one.
- R4: No command goes to a rank while its `banksIdle` bit is low. After a `preAllPulse` to a rank in cycle c, no command reaches it before cycle c+TRP+2.
- R5: While a rank is busy, its `ckeOut` is 1 and its `odtOut` is 0. Otherwise `ckeOut` equals `ckeIn` and `odtOut` equals `odtIn`.
- R6: With SHARED_RES=1, no two ranks are ever busy together. With SHARED_RES=0, a ready rank may receive its command while another rank is busy.
- R7: `calDone` for a rank pulses for one cycle, in the first cycle after its window in which `rankBusy` is low, and at no other time.
- R8: A request pulse in cycle c to an idle, ready rank produces the command in cycle c+2. Each request produces exactly one command, and no command is issued without a request.
- R9: During and just after reset, `zqCmd`, `rankBusy` and `calDone` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low synchronous reset |
| initReq | input | NUM_RANKS | Power-up long calibration request pulse, per rank |
| srxReq | input | NUM_RANKS | Self-refresh-exit long calibration request pulse, per rank |
| periodicReq | input | NUM_RANKS | Periodic short calibration request pulse, per rank |
| banksIdle | input | NUM_RANKS | All banks of the rank are precharged |
| preAllPulse | input | NUM_RANKS | Precharge-all issued to the rank this cycle |
| ckeIn | input | NUM_RANKS | Clock enable requested by the main scheduler |
| odtIn | input | NUM_RANKS | Termination enable requested by the main scheduler |
| zqCmd | output | 1 | Calibration command strobe |
| zqA10 | output | 1 | Address bit A10 of the command: 1 long, 0 short |
| zqRank | output | RW | Target rank of the command |
| ckeOut | output | NUM_RANKS | Clock enable to the devices |
| odtOut | output | NUM_RANKS | Termination enable to the devices |
| rankBusy | output | NUM_RANKS | Rank is inside its calibration window |
| calDone | output | NUM_RANKS | One-cycle pulse at the end of a window |

## Verification
A corrupted window counter or first-calibration flag shows up at the end of the very window it affects: the busy pulse is measured against the expected length in the cycle it falls, and the done pulse is checked in that same cycle. A wrong pending bit or priority order shows up at the next command strobe, because each strobe's rank and A10 value are compared, in order, against a queue of expected commands. A broken precharge timer or resistor-sharing rule changes the issue cycle or produces overlapping busy flags, and both are caught within a few cycles of the stimulus.

// File: rtl/zq_sched_pkg.sv
package zq_sched_pkg;
  localparam int MAX_RANKS = 16;

  typedef enum logic [1:0] {
    CLS_INIT = 2'd0,
    CLS_SRX  = 2'd1,
    CLS_PER  = 2'd2
  } zqClass_t;

  typedef struct packed {
    logic       start;
    logic       isLong;
    logic [3:0] rank;
  } zqStrobe_t;
endpackage

// File: rtl/zq_sched_ctrl.sv
module zq_sched_ctrl
  import zq_sched_pkg::*;
#(
  parameter int NUM_RANKS  = 2,
  parameter bit SHARED_RES = 1'b1,
  localparam int RW = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_RANKS-1:0] initReq,
  input  logic [NUM_RANKS-1:0] srxReq,
  input  logic [NUM_RANKS-1:0] periodicReq,
  input  logic [NUM_RANKS-1:0] banksIdle,
  input  logic [NUM_RANKS-1:0] rankBusy,
  input  logic [NUM_RANKS-1:0] trpOk,
  output zqStrobe_t            strobe,
  output logic                 cmdValid,
  output logic                 cmdA10,
  output logic [RW-1:0]        cmdRank
);
  logic [NUM_RANKS-1:0] pendInit, pendSrx, pendPer;
  logic [NUM_RANKS-1:0] ready;
  logic [NUM_RANKS-1:0] clrInit, clrSrx, clrPer;
  zqClass_t             pickCls;
  logic                 anyBusy;

  always_comb begin
    anyBusy = |rankBusy;
    for (int r = 0; r < NUM_RANKS; r++) begin
      ready[r] = !rankBusy[r] && banksIdle[r] && trpOk[r] && (!SHARED_RES || !anyBusy);
    end
    strobe  = '0;
    pickCls = CLS_PER;
    // later loops override earlier ones; descending index lets rank 0 win
    for (int r = NUM_RANKS - 1; r >= 0; r--) begin
      if (ready[r] && pendPer[r]) begin
        strobe.start = 1'b1;
        strobe.rank  = 4'(r);
        pickCls      = CLS_PER;
      end
    end
    for (int r = NUM_RANKS - 1; r >= 0; r--) begin
      if (ready[r] && pendSrx[r]) begin
        strobe.start = 1'b1;
        strobe.rank  = 4'(r);
        pickCls      = CLS_SRX;
      end
    end
    for (int r = NUM_RANKS - 1; r >= 0; r--) begin
      if (ready[r] && pendInit[r]) begin
        strobe.start = 1'b1;
        strobe.rank  = 4'(r);
        pickCls      = CLS_INIT;
      end
    end
    strobe.isLong = strobe.start && (pickCls != CLS_PER);
    for (int r = 0; r < NUM_RANKS; r++) begin
      clrInit[r] = strobe.start && (strobe.rank == 4'(r)) && (pickCls == CLS_INIT);
      clrSrx[r]  = strobe.start && (strobe.rank == 4'(r)) && (pickCls == CLS_SRX);
      clrPer[r]  = strobe.start && (strobe.rank == 4'(r)) && (pickCls == CLS_PER);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendInit <= '0;
      pendSrx  <= '0;
      pendPer  <= '0;
      cmdValid <= 1'b0;
      cmdA10   <= 1'b0;
      cmdRank  <= '0;
    end else begin
      pendInit <= (pendInit & ~clrInit) | initReq;
      pendSrx  <= (pendSrx & ~clrSrx) | srxReq;
      pendPer  <= (pendPer & ~clrPer) | periodicReq;
      cmdValid <= strobe.start;
      cmdA10   <= strobe.isLong;
      cmdRank  <= strobe.rank[RW-1:0];
    end
  end
endmodule

// File: rtl/zq_sched_timers.sv
module zq_sched_timers
  import zq_sched_pkg::*;
#(
  parameter int NUM_RANKS = 2,
  parameter int TZQINIT   = 512,
  parameter int TZQOPER   = 256,
  parameter int TZQCS     = 64,
  parameter int TRP       = 11,
  localparam int WMAX = (TZQINIT > TZQOPER) ? ((TZQINIT > TZQCS) ? TZQINIT : TZQCS)
                                            : ((TZQOPER > TZQCS) ? TZQOPER : TZQCS),
  localparam int CW = $clog2(WMAX + 1),
  localparam int TW = $clog2(TRP + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  zqStrobe_t            strobe,
  input  logic [NUM_RANKS-1:0] preAllPulse,
  output logic [NUM_RANKS-1:0] rankBusy,
  output logic [NUM_RANKS-1:0] trpOk,
  output logic [NUM_RANKS-1:0] calDone
);
  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
    logic [CW-1:0] winCnt;
    logic [CW-1:0] winLen;
    logic [TW-1:0] trpCnt;
    logic          busyR, curLong, firstDone, doneR, startR;

    assign startR = strobe.start && (strobe.rank == 4'(r));

    always_comb begin
      if (!strobe.isLong)  winLen = CW'(TZQCS);
      else if (firstDone)  winLen = CW'(TZQOPER);
      else                 winLen = CW'(TZQINIT);
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        winCnt    <= '0;
        busyR     <= 1'b0;
        curLong   <= 1'b0;
        firstDone <= 1'b0;
        doneR     <= 1'b0;
        trpCnt    <= '0;
      end else begin
        doneR <= 1'b0;
        if (startR) begin
          busyR   <= 1'b1;
          winCnt  <= winLen - CW'(1);
          curLong <= strobe.isLong;
        end else if (busyR) begin
          if (winCnt == '0) begin
            busyR <= 1'b0;
            doneR <= 1'b1;
            if (curLong) firstDone <= 1'b1;
          end else begin
            winCnt <= winCnt - CW'(1);
          end
        end
        if (preAllPulse[r])      trpCnt <= TW'(TRP);
        else if (trpCnt != '0)   trpCnt <= trpCnt - TW'(1);
      end
    end

    assign rankBusy[r] = busyR;
    assign calDone[r]  = doneR;
    assign trpOk[r]    = (trpCnt == '0) && !preAllPulse[r];
  end
endmodule

// File: rtl/zq_cal_sched.sv
module zq_cal_sched
  import zq_sched_pkg::*;
#(
  parameter int NUM_RANKS  = 2,
  parameter bit SHARED_RES = 1'b1,
  parameter int TZQINIT    = 512,
  parameter int TZQOPER    = 256,
  parameter int TZQCS      = 64,
  parameter int TRP        = 11,
  localparam int RW = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_RANKS-1:0] initReq,
  input  logic [NUM_RANKS-1:0] srxReq,
  input  logic [NUM_RANKS-1:0] periodicReq,
  input  logic [NUM_RANKS-1:0] banksIdle,
  input  logic [NUM_RANKS-1:0] preAllPulse,
  input  logic [NUM_RANKS-1:0] ckeIn,
  input  logic [NUM_RANKS-1:0] odtIn,
  output logic                 zqCmd,
  output logic                 zqA10,
  output logic [RW-1:0]        zqRank,
  output logic [NUM_RANKS-1:0] ckeOut,
  output logic [NUM_RANKS-1:0] odtOut,
  output logic [NUM_RANKS-1:0] rankBusy,
  output logic [NUM_RANKS-1:0] calDone
);
  zqStrobe_t            strobe;
  logic [NUM_RANKS-1:0] trpOk;

  zq_sched_ctrl #(.NUM_RANKS(NUM_RANKS), .SHARED_RES(SHARED_RES)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .initReq(initReq), .srxReq(srxReq), .periodicReq(periodicReq),
    .banksIdle(banksIdle), .rankBusy(rankBusy), .trpOk(trpOk),
    .strobe(strobe), .cmdValid(zqCmd), .cmdA10(zqA10), .cmdRank(zqRank)
  );

  zq_sched_timers #(
    .NUM_RANKS(NUM_RANKS), .TZQINIT(TZQINIT), .TZQOPER(TZQOPER),
    .TZQCS(TZQCS), .TRP(TRP)
  ) u_timers (
    .clk(clk), .rstN(rstN), .strobe(strobe), .preAllPulse(preAllPulse),
    .rankBusy(rankBusy), .trpOk(trpOk), .calDone(calDone)
  );

  assign ckeOut = ckeIn | rankBusy;
  assign odtOut = odtIn & ~rankBusy;
endmodule

// File: rtl/zq_cal_sched_chk.sv
module zq_cal_sched_chk #(
  parameter int NUM_RANKS  = 2,
  parameter bit SHARED_RES = 1'b1,
  localparam int RW = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 zqCmd,
  input logic [RW-1:0]        zqRank,
  input logic [NUM_RANKS-1:0] banksIdle,
  input logic [NUM_RANKS-1:0] rankBusy,
  input logic [NUM_RANKS-1:0] calDone,
  input logic [NUM_RANKS-1:0] ckeOut,
  input logic [NUM_RANKS-1:0] odtOut
);
  assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rstN)
    SHARED_RES |-> ($countones(rankBusy) <= 1));

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_chk
    assert_pins_held_R5: assert property (@(posedge clk) disable iff (!rstN)
      rankBusy[r] |-> (ckeOut[r] && !odtOut[r]));

    assert_done_at_end_R7: assert property (@(posedge clk) disable iff (!rstN)
      $fell(rankBusy[r]) |-> calDone[r]);

    assert_done_only_after_R7: assert property (@(posedge clk) disable iff (!rstN)
      calDone[r] |-> (!rankBusy[r] && $past(rankBusy[r])));

    assert_issue_ready_R4: assert property (@(posedge clk) disable iff (!rstN)
      (zqCmd && (zqRank == RW'(r))) |-> (rankBusy[r] && !$past(rankBusy[r]) && $past(banksIdle[r])));
  end
endmodule

bind zq_cal_sched zq_cal_sched_chk #(.NUM_RANKS(NUM_RANKS), .SHARED_RES(SHARED_RES)) u_chk (
  .clk(clk), .rstN(rstN), .zqCmd(zqCmd), .zqRank(zqRank), .banksIdle(banksIdle),
  .rankBusy(rankBusy), .calDone(calDone), .ckeOut(ckeOut), .odtOut(odtOut)
);

// File: tb/zq_cal_sched_tb.sv
module zq_cal_sched_tb;
  localparam int NR   = 2;
  localparam int TINI = 40;
  localparam int TOPR = 20;
  localparam int TCS  = 8;
  localparam int TRPC = 5;

  typedef struct {
    int rank;
    int a10;
    int win;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NR-1:0] initReq = '0, srxReq = '0, periodicReq = '0;
  logic [NR-1:0] banksIdle = '1, preAllPulse = '0, ckeIn = '0, odtIn = '1;
  logic zqCmd, zqA10, zqRank;
  logic [NR-1:0] ckeOut, odtOut, rankBusy, calDone;
  logic zqCmdNs, zqA10Ns, zqRankNs;
  logic [NR-1:0] ckeOutNs, odtOutNs, rankBusyNs, calDoneNs;

  int checks = 0, errors = 0, cyc = 0, overlapSeen = 0;
  bit finished = 1'b0;
  expItem_t expQ[$];
  int expWin[NR], busyLen[NR], cmdCyc[NR];
  logic [NR-1:0] prevBusy = '0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  zq_cal_sched #(.NUM_RANKS(NR), .SHARED_RES(1'b1), .TZQINIT(TINI), .TZQOPER(TOPR),
                 .TZQCS(TCS), .TRP(TRPC)) u_dut (
    .clk(clk), .rstN(rstN), .initReq(initReq), .srxReq(srxReq), .periodicReq(periodicReq),
    .banksIdle(banksIdle), .preAllPulse(preAllPulse), .ckeIn(ckeIn), .odtIn(odtIn),
    .zqCmd(zqCmd), .zqA10(zqA10), .zqRank(zqRank), .ckeOut(ckeOut), .odtOut(odtOut),
    .rankBusy(rankBusy), .calDone(calDone));

  zq_cal_sched #(.NUM_RANKS(NR), .SHARED_RES(1'b0), .TZQINIT(TINI), .TZQOPER(TOPR),
                 .TZQCS(TCS), .TRP(TRPC)) u_dutNs (
    .clk(clk), .rstN(rstN), .initReq(initReq), .srxReq(srxReq), .periodicReq(periodicReq),
    .banksIdle(banksIdle), .preAllPulse(preAllPulse), .ckeIn(ckeIn), .odtIn(odtIn),
    .zqCmd(zqCmdNs), .zqA10(zqA10Ns), .zqRank(zqRankNs), .ckeOut(ckeOutNs), .odtOut(odtOutNs),
    .rankBusy(rankBusyNs), .calDone(calDoneNs));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic expect_cmd(input int rank, input int a10, input int win);
    expItem_t it;
    it.rank = rank; it.a10 = a10; it.win = win;
    expQ.push_back(it);
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (expQ.size() != 0 || rankBusy != '0 || rankBusyNs != '0);
    repeat (2) @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN) begin
      if (zqCmd) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R8 command without request", int'(zqRank), -1);
        end else begin
          expItem_t it;
          it = expQ.pop_front();
          check(int'(zqRank) == it.rank, "R2 rank order", int'(zqRank), it.rank);
          check(int'(zqA10) == it.a10, "R1 A10 value", int'(zqA10), it.a10);
          expWin[zqRank] = it.win;
          busyLen[zqRank] = 0;
          cmdCyc[zqRank] = cyc;
        end
      end
      for (int r = 0; r < NR; r++) begin
        if (rankBusy[r]) busyLen[r]++;
        else if (prevBusy[r]) begin
          check(busyLen[r] == expWin[r], "R3 window length", busyLen[r], expWin[r]);
          check(calDone[r], "R7 done at window end", int'(calDone[r]), 1);
        end else if (calDone[r]) begin
          check(1'b0, "R7 stray done", 1, 0);
        end
      end
      prevBusy = rankBusy;
      if ($countones(rankBusy) > 1) overlapSeen++;
    end
  end

  initial begin
    int c0;
    int quietCmds;
    repeat (3) @(negedge clk);
    check(zqCmd == 1'b0, "R9 reset cmd", int'(zqCmd), 0);
    check(rankBusy == '0, "R9 reset busy", int'(rankBusy), 0);
    check(calDone == '0, "R9 reset done", int'(calDone), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(ckeOut == ckeIn && odtOut == odtIn, "R5 pass-through idle",
          int'({ckeOut, odtOut}), int'({ckeIn, odtIn}));

    // power-up on both ranks: rank0 then rank1, long, first windows
    expect_cmd(0, 1, TINI);
    expect_cmd(1, 1, TINI);
    initReq = 2'b11;
    @(negedge clk); initReq = '0;
    @(negedge clk);
    check(zqCmd && zqRank == 1'b0, "R8 two-cycle latency", int'(zqCmd), 1);
    check(ckeOut == 2'b01, "R5 cke held", int'(ckeOut), 1);
    check(odtOut == 2'b10, "R5 odt forced off", int'(odtOut), 2);
    wait_idle();

    // class priority on one rank: self-refresh exit before periodic
    expect_cmd(0, 1, TOPR);
    expect_cmd(0, 0, TCS);
    srxReq = 2'b01; periodicReq = 2'b01;
    @(negedge clk); srxReq = '0; periodicReq = '0;
    wait_idle();

    // class priority across ranks: rank1 long before rank0 short
    expect_cmd(1, 1, TOPR);
    expect_cmd(0, 0, TCS);
    periodicReq = 2'b01; srxReq = 2'b10;
    @(negedge clk); periodicReq = '0; srxReq = '0;
    wait_idle();

    // precharge time
    expect_cmd(1, 0, TCS);
    c0 = cyc;
    preAllPulse = 2'b10; periodicReq = 2'b10;
    @(negedge clk); preAllPulse = '0; periodicReq = '0;
    wait_idle();
    check(cmdCyc[1] - c0 == TRPC + 2, "R4 precharge delay", cmdCyc[1] - c0, TRPC + 2);

    // banks not idle blocks the command
    banksIdle = 2'b10;
    periodicReq = 2'b01;
    @(negedge clk); periodicReq = '0;
    quietCmds = 0;
    repeat (30) begin
      @(negedge clk);
      if (zqCmd) quietCmds++;
    end
    check(quietCmds == 0, "R4 banks open blocks", quietCmds, 0);
    expect_cmd(0, 0, TCS);
    banksIdle = 2'b11;
    wait_idle();

    // no request, no command
    quietCmds = 0;
    repeat (50) begin
      @(negedge clk);
      if (zqCmd || zqCmdNs) quietCmds++;
    end
    check(quietCmds == 0, "R8 no implicit command", quietCmds, 0);

    // shared versus unshared resistor
    expect_cmd(0, 1, TOPR);
    expect_cmd(1, 1, TOPR);
    initReq = 2'b11;
    @(negedge clk); initReq = '0;
    repeat (3) @(negedge clk);
    check(rankBusyNs == 2'b11, "R6 unshared overlap allowed", int'(rankBusyNs), 3);
    check(rankBusy == 2'b01, "R6 shared serialised", int'(rankBusy), 1);
    wait_idle();

    check(overlapSeen == 0, "R6 no overlap shared", overlapSeen, 0);
    check(expQ.size() == 0, "R8 all requests served", expQ.size(), 0);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog expired", cyc, 20000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule